// File: doc/BRIEF.md
# Two-Level Gated Interrupt Controller

This block collects level-sensitive interrupt sources and presents one interrupt line to each of up to four CPUs. Every source must pass two independent gates before it reaches a CPU. The first gate is a single global enable bit per source. The second is a mask bit per source and per CPU. Software changes both gates by writing a source index to a set or clear register. There is no bitmask and no read-modify-write, so CPUs that write at the same time cannot undo each other's changes.

The lower sources (index below `NUM_PERCPU`) are private to each CPU. The routing mask is not used for them, and each CPU decides on its own whether to take them by means of its mask. The higher sources are shared. Each shared source also needs its CPU's bit set in a per-source routing register.

Each CPU reads an acknowledge register. It returns the lowest-numbered source that is currently deliverable to that CPU, or a "none" code. Reading it does not clear anything, because sources are level-sensitive.

The register port has a global bank and a per-CPU bank, chosen by a bank-select input. Accesses to the per-CPU bank always act on the CPU given on the CPU-id input.

Top module: `dgi_top`

## Requirements
- R1: After reset, every source is globally disabled, masked on every CPU, and routed to no CPU. Every `cpu_irq` bit is 0 and every acknowledge read returns 1023.
- R2: In the global bank, writing an index to offset 0x30 sets that source's global enable, and writing it to offset 0x34 clears the enable.
- R3: In the per-CPU bank, writing an index to offset 0x48 masks that source and writing it to offset 0x4C unmasks it. Only the CPU named on `bus_cpu` is affected.
- R4: The routing register of source i is at global offset 0x100 + 4*i. Bits [NUM_CPU-1:0] hold the target CPU mask and read back as written. Higher bits read as 0.
- R5: A shared source (index >= NUM_PERCPU, default 29) reaches CPU c only when four conditions hold together: the source is asserted, it is globally enabled, it is unmasked for c, and bit c of its routing mask is set.
- R6: A per-CPU source (index < NUM_PERCPU) reaches CPU c when it is asserted, enabled and unmasked for c, whatever its routing register holds.
- R7: Reading global offset 0x00 returns NUM_SRC in bits [12:2]. All other bits of that read are 0.
- R8: Reading per-CPU offset 0x44 returns, in bits [9:0], the lowest-numbered source deliverable to that CPU, or 1023 when none is deliverable. The read does not change any state.
- R9: A set or clear write whose index (bits [9:0] of the data) is NUM_SRC or more has no effect.
- R10: Read data appears on `bus_rdata` on the clock edge after `bus_rd` is sampled high. Offsets that map to nothing read as 0.
- R11: `cpu_irq[c]` is high exactly when at least one source is deliverable to CPU c. It follows `src_in` and the register state combinationally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| src_in | input | NUM_SRC | Level interrupt sources |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_bank | input | 1 | 0 = global bank, 1 = per-CPU bank |
| bus_cpu | input | CPU_W | Id of the CPU issuing the access |
| bus_addr | input | 12 | Byte offset within the bank |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| cpu_irq | output | NUM_CPU | Interrupt line per CPU |

## Verification
The assertions assume several things about the inputs. `bus_cpu` always names an implemented CPU. Reset is held for at least one clock edge before the first access. No write and read are issued to the same location in the same cycle. When a write carries an index of NUM_SRC or more, the assertions only check that nothing changes.

The stimulus keeps within these limits. It drives a single access per cycle and draws CPU ids only from the implemented range. It draws indices from a range a little wider than NUM_SRC, so that ignored writes occur often. It also redraws `src_in` at random between accesses, so that delivery and acknowledge are compared against a model under many different mixes of enables, masks and routes.

// File: rtl/dgi_pkg.sv
// Package: shared constants, bank encoding and address helpers for the
// two-level gated interrupt controller. Assumes a 12-bit byte address.
package dgi_pkg;
    localparam int ADDR_W = 12;
    localparam int DATA_W = 32;
    localparam int ID_W   = 10;

    localparam logic [ADDR_W-1:0] OFF_CTRL       = 12'h000;
    localparam logic [ADDR_W-1:0] OFF_EN_SET     = 12'h030;
    localparam logic [ADDR_W-1:0] OFF_EN_CLR     = 12'h034;
    localparam logic [ADDR_W-1:0] OFF_ACK        = 12'h044;
    localparam logic [ADDR_W-1:0] OFF_MSK_SET    = 12'h048;
    localparam logic [ADDR_W-1:0] OFF_MSK_CLR    = 12'h04C;
    localparam logic [ADDR_W-1:0] OFF_ROUTE_BASE = 12'h100;

    localparam logic [ID_W-1:0] ID_NONE = 10'd1023;

    typedef enum logic {BANK_GLOBAL = 1'b0, BANK_CPU = 1'b1} bank_e;

    // Word index of a routing-register address.
    function automatic logic [ID_W-1:0] route_index(input logic [ADDR_W-1:0] a);
        logic [ADDR_W-1:0] off;
        off = a - OFF_ROUTE_BASE;
        return off[ADDR_W-1:2];
    endfunction

    // True when the address is an aligned routing register of an implemented source.
    function automatic logic route_hit(input logic [ADDR_W-1:0] a, input int nsrc);
        return (a >= OFF_ROUTE_BASE) && (a[1:0] == 2'b00) &&
               (int'(route_index(a)) < nsrc);
    endfunction
endpackage

// File: rtl/dgi_regs.sv
// Module: dgi_regs
// Holds the global enable bits, the per-CPU mask bits and the routing masks.
// Decodes index-style set/clear writes and routing writes.
// Assumes: one access per cycle; bus_cpu < NUM_CPU; ignores indices >= NUM_SRC.
module dgi_regs
    import dgi_pkg::*;
#(
    parameter int NUM_SRC = 64,
    parameter int NUM_CPU = 4,
    localparam int CPU_W  = (NUM_CPU > 1) ? $clog2(NUM_CPU) : 1,
    localparam int SRC_W  = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              bus_wr,
    input  logic                              bus_bank,
    input  logic [CPU_W-1:0]                  bus_cpu,
    input  logic [ADDR_W-1:0]                 bus_addr,
    input  logic [DATA_W-1:0]                 bus_wdata,
    output logic [NUM_SRC-1:0]                en_o,
    output logic [NUM_CPU-1:0][NUM_SRC-1:0]   mask_o,
    output logic [NUM_SRC-1:0][NUM_CPU-1:0]   route_o
);
    logic [NUM_SRC-1:0]              en_q;
    logic [NUM_CPU-1:0][NUM_SRC-1:0] mask_q;
    logic [NUM_SRC-1:0][NUM_CPU-1:0] route_q;

    logic [ID_W-1:0]  widx;
    logic [SRC_W-1:0] widx_s;
    logic             idx_ok;
    logic             g_wr, c_wr;
    logic             en_set, en_clr, msk_set, msk_clr, rt_wr;
    logic [ID_W-1:0]  rt_idx;
    logic [SRC_W-1:0] rt_idx_s;

    // Decode the write strobes and the source index carried in the data.
    always_comb begin
        widx     = bus_wdata[ID_W-1:0];
        widx_s   = widx[SRC_W-1:0];
        idx_ok   = (int'(widx) < NUM_SRC);
        g_wr     = bus_wr && (bus_bank == BANK_GLOBAL);
        c_wr     = bus_wr && (bus_bank == BANK_CPU) && (int'(bus_cpu) < NUM_CPU);
        en_set   = g_wr && (bus_addr == OFF_EN_SET)  && idx_ok;
        en_clr   = g_wr && (bus_addr == OFF_EN_CLR)  && idx_ok;
        msk_set  = c_wr && (bus_addr == OFF_MSK_SET) && idx_ok;
        msk_clr  = c_wr && (bus_addr == OFF_MSK_CLR) && idx_ok;
        rt_idx   = route_index(bus_addr);
        rt_idx_s = rt_idx[SRC_W-1:0];
        rt_wr    = g_wr && route_hit(bus_addr, NUM_SRC);
    end

    // Global enable stage: index-addressed set and clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q <= '0;
        end else if (en_set) begin
            en_q[widx_s] <= 1'b1;
        end else if (en_clr) begin
            en_q[widx_s] <= 1'b0;
        end
    end

    // Per-CPU mask stage: only the accessing CPU's row changes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask_q <= '1;
        end else if (msk_set) begin
            mask_q[bus_cpu][widx_s] <= 1'b1;
        end else if (msk_clr) begin
            mask_q[bus_cpu][widx_s] <= 1'b0;
        end
    end

    // Routing masks: one CPU mask per source, written as a field.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            route_q <= '0;
        end else if (rt_wr) begin
            route_q[rt_idx_s] <= bus_wdata[NUM_CPU-1:0];
        end
    end

    assign en_o    = en_q;
    assign mask_o  = mask_q;
    assign route_o = route_q;

    AST_EN_SET_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
        en_set |=> en_q[$past(widx_s)]); // R2
    AST_EN_CLR_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
        en_clr |=> !en_q[$past(widx_s)]); // R2
    AST_MSK_SET_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
        msk_set |=> mask_q[$past(bus_cpu)][$past(widx_s)]); // R3
    AST_MSK_CLR_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
        msk_clr |=> !mask_q[$past(bus_cpu)][$past(widx_s)]); // R3
    AST_BAD_IDX_NO_EFFECT: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && !idx_ok && !rt_wr) |=> ($stable(en_q) && $stable(mask_q))); // R9
    AST_ROUTE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !rt_wr |=> $stable(route_q)); // R4
endmodule

// File: rtl/dgi_cpu_port.sv
// Module: dgi_cpu_port
// For one CPU: forms the deliverable-source vector and finds its lowest
// index for the acknowledge register. Shared sources also need the CPU's
// routing bit. Assumes all inputs are registered state or level sources.
module dgi_cpu_port
    import dgi_pkg::*;
#(
    parameter int NUM_SRC    = 64,
    parameter int NUM_PERCPU = 29,
    localparam int SRC_W     = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] src_i,
    input  logic [NUM_SRC-1:0] en_i,
    input  logic [NUM_SRC-1:0] mask_i,
    input  logic [NUM_SRC-1:0] route_i,
    output logic               irq_o,
    output logic [ID_W-1:0]    ack_o
);
    logic [NUM_SRC-1:0] private_src;
    logic [NUM_SRC-1:0] elig;
    logic               found;
    logic [SRC_W-1:0]   ack_s;

    // Constant class map: 1 marks a per-CPU source that skips routing.
    for (genvar s = 0; s < NUM_SRC; s++) begin : g_class
        assign private_src[s] = (s < NUM_PERCPU);
    end

    // Two-level gating plus routing for shared sources.
    assign elig = src_i & en_i & ~mask_i & (route_i | private_src);

    // Lowest-index search over the deliverable vector.
    always_comb begin
        found = 1'b0;
        ack_o = ID_NONE;
        for (int i = NUM_SRC - 1; i >= 0; i--) begin
            if (elig[i]) begin
                found = 1'b1;
                ack_o = ID_W'(i);
            end
        end
    end

    assign irq_o = found;
    assign ack_s = ack_o[SRC_W-1:0];

    AST_ACK_IS_LIVE: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_o != ID_NONE) |-> (src_i[ack_s] && en_i[ack_s] && !mask_i[ack_s])); // R8
    AST_ACK_IS_LOWEST: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_o != ID_NONE) |-> ((elig & ((NUM_SRC'(1) << ack_s) - NUM_SRC'(1))) == '0)); // R8
    AST_SHARED_NEEDS_ROUTE: assert property (@(posedge clk) disable iff (!rst_n)
        ((ack_o != ID_NONE) && (int'(ack_o) >= NUM_PERCPU)) |-> route_i[ack_s]); // R5
    AST_IRQ_IFF_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o == (ack_o != ID_NONE)); // R11
endmodule

// File: rtl/dgi_top.sv
// Module: dgi_top
// Two-level gated interrupt controller: global enable, per-CPU mask and
// per-source routing, with a banked register port and one acknowledge
// register per CPU. Assumes bus_cpu names the CPU issuing each access.
module dgi_top
    import dgi_pkg::*;
#(
    parameter int NUM_SRC    = 64,
    parameter int NUM_CPU    = 4,
    parameter int NUM_PERCPU = 29,
    localparam int CPU_W     = (NUM_CPU > 1) ? $clog2(NUM_CPU) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] src_in,
    input  logic               bus_wr,
    input  logic               bus_rd,
    input  logic               bus_bank,
    input  logic [CPU_W-1:0]   bus_cpu,
    input  logic [11:0]        bus_addr,
    input  logic [31:0]        bus_wdata,
    output logic [31:0]        bus_rdata,
    output logic [NUM_CPU-1:0] cpu_irq
);
    localparam int SRC_W = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1;

    logic [NUM_SRC-1:0]              en_w;
    logic [NUM_CPU-1:0][NUM_SRC-1:0] mask_w;
    logic [NUM_SRC-1:0][NUM_CPU-1:0] route_w;
    logic [NUM_CPU-1:0][NUM_SRC-1:0] route_col;
    logic [NUM_CPU-1:0][ID_W-1:0]    ack_w;
    logic [DATA_W-1:0]               rd_next;
    logic [ID_W-1:0]                 rt_idx;
    logic [SRC_W-1:0]                rt_idx_s;

    dgi_regs #(.NUM_SRC(NUM_SRC), .NUM_CPU(NUM_CPU)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_wr    (bus_wr),
        .bus_bank  (bus_bank),
        .bus_cpu   (bus_cpu),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .en_o      (en_w),
        .mask_o    (mask_w),
        .route_o   (route_w)
    );

    for (genvar c = 0; c < NUM_CPU; c++) begin : g_cpu
        for (genvar s = 0; s < NUM_SRC; s++) begin : g_col
            assign route_col[c][s] = route_w[s][c];
        end
        dgi_cpu_port #(.NUM_SRC(NUM_SRC), .NUM_PERCPU(NUM_PERCPU)) u_port (
            .clk     (clk),
            .rst_n   (rst_n),
            .src_i   (src_in),
            .en_i    (en_w),
            .mask_i  (mask_w[c]),
            .route_i (route_col[c]),
            .irq_o   (cpu_irq[c]),
            .ack_o   (ack_w[c])
        );
    end

    // Read multiplexer for both banks; unmapped offsets give zero.
    always_comb begin
        rd_next  = '0;
        rt_idx   = route_index(bus_addr);
        rt_idx_s = rt_idx[SRC_W-1:0];
        if (bus_bank == BANK_GLOBAL) begin
            if (bus_addr == OFF_CTRL) begin
                rd_next[12:2] = 11'(NUM_SRC);
            end else if (route_hit(bus_addr, NUM_SRC)) begin
                rd_next[NUM_CPU-1:0] = route_w[rt_idx_s];
            end
        end else if ((bus_addr == OFF_ACK) && (int'(bus_cpu) < NUM_CPU)) begin
            rd_next[ID_W-1:0] = ack_w[bus_cpu];
        end
    end

    // Registered read data, loaded on a read strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bus_rdata <= '0;
        end else if (bus_rd) begin
            bus_rdata <= rd_next;
        end
    end

    AST_QUIET_AFTER_RESET: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!rst_n) |-> (cpu_irq == '0)); // R1
    AST_RDATA_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (!bus_rd && $past(rst_n)) |=> $stable(bus_rdata)); // R10
endmodule

// File: tb/dgi_top_tb.sv
module dgi_top_tb;
    localparam int NS = 64;
    localparam int NC = 4;
    localparam int NP = 29;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [NS-1:0] src_in = '0;
    logic          bus_wr = 1'b0, bus_rd = 1'b0, bus_bank = 1'b0;
    logic [1:0]    bus_cpu = '0;
    logic [11:0]   bus_addr = '0;
    logic [31:0]   bus_wdata = '0;
    logic [31:0]   bus_rdata;
    logic [NC-1:0] cpu_irq;

    int checks = 0;
    int errors = 0;

    bit          m_en [NS];
    bit          m_msk [NC][NS];
    logic [3:0]  m_rt [NS];

    dgi_top #(.NUM_SRC(NS), .NUM_CPU(NC), .NUM_PERCPU(NP)) u_dut (
        .clk(clk), .rst_n(rst_n), .src_in(src_in), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_bank(bus_bank), .bus_cpu(bus_cpu), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .cpu_irq(cpu_irq)
    );

    always #5 clk = ~clk;

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic bit deliv(input int c, input int i);
        return src_in[i] && m_en[i] && !m_msk[c][i] && ((i < NP) || m_rt[i][c]);
    endfunction

    function automatic int exp_ack(input int c);
        for (int i = 0; i < NS; i++) if (deliv(c, i)) return i;
        return 1023;
    endfunction

    function automatic int exp_irq();
        int v = 0;
        for (int c = 0; c < NC; c++) if (exp_ack(c) != 1023) v |= (1 << c);
        return v;
    endfunction

    task automatic wr(input bit bank, input int cpu, input int addr, input int data);
        @(negedge clk);
        bus_wr = 1'b1; bus_bank = bank; bus_cpu = 2'(cpu);
        bus_addr = 12'(addr); bus_wdata = data;
        @(negedge clk);
        bus_wr = 1'b0;
        if (data >= 0 && data < NS) begin
            if (!bank && addr == 'h30) m_en[data] = 1;
            if (!bank && addr == 'h34) m_en[data] = 0;
            if (bank && addr == 'h48) m_msk[cpu][data] = 1;
            if (bank && addr == 'h4C) m_msk[cpu][data] = 0;
        end
        if (!bank && addr >= 'h100 && addr < 'h100 + 4*NS && addr[1:0] == 0)
            m_rt[(addr - 'h100) / 4] = 4'(data);
    endtask

    task automatic rd(input bit bank, input int cpu, input int addr, output int data);
        @(negedge clk);
        bus_rd = 1'b1; bus_bank = bank; bus_cpu = 2'(cpu); bus_addr = 12'(addr);
        @(negedge clk);
        bus_rd = 1'b0;
        data = int'(bus_rdata);
    endtask

    initial begin
        #2_000_000;
        errors++;
        $display("FAIL watchdog: actual 1 expected 0");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int v;
        void'($urandom(32'h5EED_1234));
        for (int i = 0; i < NS; i++) begin
            m_en[i] = 0; m_rt[i] = 0;
            for (int c = 0; c < NC; c++) m_msk[c][i] = 1;
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        src_in = '1;
        #1;
        chk("R1 irq after reset", int'(cpu_irq), 0);
        for (int c = 0; c < NC; c++) begin
            rd(1, c, 'h44, v); chk("R1 ack none", v, 1023);
        end
        rd(0, 0, 'h140, v); chk("R1 route zero", v, 0);
        rd(0, 0, 'h000, v); chk("R7 control", v, NS << 2);
        rd(0, 0, 'h200, v); chk("R10 unmapped", v, 0);
        rd(1, 0, 'h030, v); chk("R10 unmapped cpu bank", v, 0);

        src_in = '0; src_in[5] = 1; src_in[40] = 1;
        wr(0, 0, 'h30, 5); wr(0, 0, 'h30, 40);
        wr(1, 1, 'h4C, 5); wr(1, 1, 'h4C, 40);
        #1;
        chk("R6 private source ignores route", int'(cpu_irq), 'b0010);
        rd(1, 1, 'h44, v); chk("R6 ack", v, 5);
        rd(1, 1, 'h44, v); chk("R8 ack repeat no clear", v, 5);
        wr(1, 1, 'h48, 5); #1;
        chk("R5 shared unrouted blocked", int'(cpu_irq), 0);
        wr(0, 0, 'h100 + 4*40, 'hFF);
        rd(0, 0, 'h100 + 4*40, v); chk("R4 route readback", v, 'hF);
        #1; chk("R5 shared routed", int'(cpu_irq), 'b0010);
        rd(1, 2, 'h44, v); chk("R3 other cpu still masked", v, 1023);
        rd(1, 1, 'h44, v); chk("R5 ack shared", v, 40);
        wr(0, 0, 'h34, 40); #1;
        chk("R2 clear enable", int'(cpu_irq), 0);

        src_in = '0; src_in[0] = 1;
        wr(1, 0, 'h4C, 0);
        wr(0, 0, 'h30, NS); wr(0, 0, 'h30, NS + 256); #1;
        chk("R9 out-of-range enable ignored", int'(cpu_irq), 0);
        wr(0, 0, 'h30, 0); #1;
        chk("R11 irq source 0", int'(cpu_irq), 'b0001);
        wr(1, 0, 'h48, NS); #1;
        chk("R9 out-of-range mask ignored", int'(cpu_irq), 'b0001);

        for (int it = 0; it < 600; it++) begin
            int op  = $urandom % 7;
            int idx = $urandom % (NS + 6);
            int cpu = $urandom % NC;
            case (op)
                0: wr(0, cpu, 'h30, idx);
                1: wr(0, cpu, 'h34, idx);
                2: wr(1, cpu, 'h48, idx);
                3, 4: wr(1, cpu, 'h4C, idx);
                5: wr(0, cpu, 'h100 + 4*(idx % NS), $urandom);
                default: begin
                    @(negedge clk);
                    src_in = {$urandom, $urandom} & {$urandom, $urandom};
                end
            endcase
            #1;
            chk("R11 random irq", int'(cpu_irq), exp_irq());
            if (it % 3 == 0) begin
                rd(1, cpu, 'h44, v); chk("R8 random ack", v, exp_ack(cpu));
            end
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule